// File: doc/BRIEF.md
# Programmable SPI Byte-Shift Engine

A register-driven, single-lane SPI master that runs one programmable command frame at a time. Software fills a six-byte transmit bank and sets a transfer length in bits. Setting the start bit in the command register then runs the frame. The engine lowers chip select and produces SCLK from a clock divider. It drives MOSI from the transmit bank, starting with the highest-indexed byte, and shifts MISO into a ten-byte receive chain on every rising SCLK edge.

Opcode, address, dummy and data phases are all carried by this one frame. Once the transmit bank is used up, MOSI carries zeros. The engine clears the start bit when the frame ends, so software polls that bit to see completion. It then reads the received bytes, where receive byte 0 is the most recent. The `done_o` pulse gives the same event to logic inside the chip.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, busy_o is 0, and the command (address 0) and bit-count (address 1) registers read 0.
- R2: Register map on the 5-bit address: 0 is the 6-bit command register with the start bit at bit 2. 1 is the bit count. 8+i is transmit byte i (i = 0..5). 16+i is receive byte i (i = 0..9). All are readable; the receive bytes are read-only.
- R3: MOSI sends transmit byte 5 first, then bytes 4 down to 0, each MSB first. Every bit after the 48th is 0.
- R4: A bit-count write above 56 stores 56. A frame produces exactly as many SCLK pulses as the stored count.
- R5: The receive chain is cleared when a frame starts. Each sampled bit enters at bit 0 of receive byte 0 and moves up through the chain, so byte 0 holds the last 8 bits received and byte 1 the 8 before those.
- R6: Mode 0 is used. SCLK idles low. MOSI changes only while SCLK is low and holds while SCLK is high. MISO is sampled on the rising edge.
- R7: Chip select goes low CLK_DIV_HALF clock cycles before the first SCLK rise, and high CLK_DIV_HALF cycles after the last SCLK fall. SCLK high and low phases each last CLK_DIV_HALF cycles.
- R8: The start bit reads 1 for the whole time busy_o is high. It clears in the same cycle that chip select rises, and done_o pulses for one cycle in that cycle.
- R9: While busy_o is high, register writes have no effect.
- R10: A start with a bit count of 0 never sets the start bit and leaves chip select high. done_o pulses on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from address) |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
A start write takes effect at the clock edge that captures it, so chip select falls in that cycle. The first SCLK rise follows CLK_DIV_HALF cycles later, and each later edge CLK_DIV_HALF cycles after the one before. The scoreboard therefore compares MOSI against its queue at each SCLK rise, half a period after the bit was launched. It changes MISO only on SCLK falls, which keeps each sampled bit stable for a full half period. The bench times the chip-select lead and trail from edge timestamps. It reads the receive bank and the start bit only after the done pulse, which it counts on falling clock edges. For a zero-length start, it checks three cycles later that the done pulse has occurred and that chip select never fell.

// File: rtl/spi_se_pkg.sv
package spi_se_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_CMD = 5'd0;
  localparam logic [ADDR_W-1:0] A_CNT = 5'd1;
  localparam logic [ADDR_W-1:0] A_TX  = 5'd8;
  localparam logic [ADDR_W-1:0] A_RX  = 5'd16;
  localparam int unsigned START_BIT = 2;
  localparam int unsigned CMD_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TRAIL
  } phase_e;
endpackage

// File: rtl/spi_se_clkdiv.sv
module spi_se_clkdiv #(
  parameter int unsigned HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == W'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/spi_se_regs.sv
module spi_se_regs
  import spi_se_pkg::*;
#(
  parameter int unsigned TX_BYTES = 6,
  parameter int unsigned RX_BYTES = 10,
  parameter int unsigned BIT_MAX  = 56,
  parameter int unsigned CNT_W    = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [7:0]              wdata_i,
  output logic [7:0]              rdata_o,
  input  logic                    busy_i,
  input  logic                    fin_i,
  input  logic [RX_BYTES*8-1:0]   rx_chain_i,
  output logic [TX_BYTES*8-1:0]   tx_vec_o,
  output logic [CNT_W-1:0]        bit_cnt_o,
  output logic                    start_o,
  output logic                    zero_o
);
  logic [CMD_W-1:0] cmd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       tx_q [TX_BYTES];
  logic             wr_ok, cmd_go;

  assign wr_ok  = we_i && !busy_i;
  assign cmd_go = wr_ok && (addr_i == A_CMD) && wdata_i[START_BIT];
  assign start_o = cmd_go && (cnt_q != '0);
  assign zero_o  = cmd_go && (cnt_q == '0);
  assign bit_cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      cnt_q <= '0;
    end else begin
      if (fin_i) cmd_q[START_BIT] <= 1'b0;
      if (wr_ok && addr_i == A_CMD) begin
        cmd_q <= wdata_i[CMD_W-1:0];
        cmd_q[START_BIT] <= start_o;
      end
      if (wr_ok && addr_i == A_CNT)
        cnt_q <= (wdata_i > 8'(BIT_MAX)) ? CNT_W'(BIT_MAX) : wdata_i[CNT_W-1:0];
    end
  end

  for (genvar g = 0; g < TX_BYTES; g++) begin : g_tx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   tx_q[g] <= '0;
      else if (wr_ok && addr_i == A_TX + ADDR_W'(g)) tx_q[g] <= wdata_i;
    end
    assign tx_vec_o[8*g +: 8] = tx_q[g];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CMD) rdata_o = 8'(cmd_q);
    if (addr_i == A_CNT) rdata_o = 8'(cnt_q);
    for (int i = 0; i < TX_BYTES; i++)
      if (addr_i == A_TX + ADDR_W'(i)) rdata_o = tx_q[i];
    for (int i = 0; i < RX_BYTES; i++)
      if (addr_i == A_RX + ADDR_W'(i)) rdata_o = rx_chain_i[8*i +: 8];
  end
endmodule

// File: rtl/spi_se_shifter.sv
module spi_se_shifter
  import spi_se_pkg::*;
#(
  parameter int unsigned TX_W  = 48,
  parameter int unsigned RX_W  = 80,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TX_W-1:0]  tx_vec_i,
  input  logic [CNT_W-1:0] bit_cnt_i,
  input  logic             tick_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             mosi_o,
  output logic [RX_W-1:0]  rx_chain_o
);
  phase_e           state_q;
  logic [TX_W-1:0]  tx_sh_q;
  logic [RX_W-1:0]  rx_q;
  logic [CNT_W-1:0] left_q;

  assign busy_o     = (state_q != ST_IDLE);
  assign cs_no      = (state_q == ST_IDLE);
  assign sclk_o     = (state_q == ST_HIGH);
  assign mosi_o     = busy_o && tx_sh_q[TX_W-1];
  assign fin_o      = (state_q == ST_TRAIL) && tick_i;
  assign rx_chain_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tx_sh_q <= '0;
      rx_q    <= '0;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LEAD;
          tx_sh_q <= tx_vec_i;
          rx_q    <= '0;
          left_q  <= bit_cnt_i;
        end
        ST_LEAD, ST_LOW: if (tick_i) begin
          state_q <= ST_HIGH;
          rx_q    <= {rx_q[RX_W-2:0], miso_i};
        end
        ST_HIGH: if (tick_i) begin
          left_q <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            state_q <= ST_TRAIL;
          end else begin
            state_q <= ST_LOW;
            tx_sh_q <= {tx_sh_q[TX_W-2:0], 1'b0};
          end
        end
        ST_TRAIL: if (tick_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_se_pkg::*;
#(
  parameter int unsigned CLK_DIV_HALF = 2,
  parameter int unsigned TX_BYTES     = 6,
  parameter int unsigned RX_BYTES     = 10,
  parameter int unsigned BIT_MAX      = 56
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [4:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       cs_no,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int unsigned TX_W  = TX_BYTES * 8;
  localparam int unsigned RX_W  = RX_BYTES * 8;
  localparam int unsigned CNT_W = $clog2(BIT_MAX + 1);

  logic [TX_W-1:0]  tx_vec;
  logic [RX_W-1:0]  rx_chain;
  logic [CNT_W-1:0] bit_cnt;
  logic             start, zero, fin, tick, done_q;

  spi_se_regs #(
    .TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES), .BIT_MAX(BIT_MAX), .CNT_W(CNT_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy_o), .fin_i(fin), .rx_chain_i(rx_chain),
    .tx_vec_o(tx_vec), .bit_cnt_o(bit_cnt), .start_o(start), .zero_o(zero)
  );

  spi_se_clkdiv #(.HALF(CLK_DIV_HALF)) u_div (
    .clk_i, .rst_ni, .en_i(busy_o), .tick_o(tick)
  );

  spi_se_shifter #(.TX_W(TX_W), .RX_W(RX_W), .CNT_W(CNT_W)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .tx_vec_i(tx_vec), .bit_cnt_i(bit_cnt),
    .tick_i(tick), .miso_i, .busy_o, .fin_o(fin), .sclk_o, .cs_no, .mosi_o,
    .rx_chain_o(rx_chain)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= fin | zero;
  end
  assign done_o = done_q;
endmodule

// File: rtl/spi_shift_engine_checker.sv
module spi_shift_engine_checker
  import spi_se_pkg::*;
#(
  parameter int unsigned BIT_MAX = 56
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] reg_addr_i,
  input logic [7:0] reg_rdata_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       cs_no,
  input logic       sclk_o,
  input logic       mosi_o
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o); // R6
  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R6
  AST_CNT_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_CNT) |-> (reg_rdata_o <= 8'(BIT_MAX))); // R4
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !busy_o)); // R8
  AST_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reg_addr_i == A_CMD) |-> reg_rdata_o[START_BIT]); // R8
  AST_CS_RISE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> done_o); // R8
endmodule

bind spi_shift_engine spi_shift_engine_checker #(.BIT_MAX(BIT_MAX)) u_chk (
  .clk_i, .rst_ni, .reg_addr_i, .reg_rdata_o, .busy_o, .done_o, .cs_no, .sclk_o, .mosi_o
);

// File: tb/spi_shift_engine_tb_top.sv
module spi_shift_engine_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int HALF    = 2;
  localparam int HALF_NS = HALF * 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic busy, done, cs_n, sclk, mosi, miso;

  int n_tests = 0, n_fail = 0;
  bit exp_q[$];
  logic [79:0] miso_pat = '0;
  int mi = 0, rises = 0, cs_falls = 0, done_cnt = 0;
  time t_csf = 0;
  time t_fall = 0;
  bit first = 0, fall_seen = 0;

  always #2 clk = ~clk;

  assign miso = (mi < 80) ? miso_pat[79 - mi] : 1'b0;

  spi_shift_engine #(.CLK_DIV_HALF(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .busy_o(busy), .done_o(done), .cs_no(cs_n), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop on each SCLK rise
  always @(posedge sclk) begin
    if (first) begin
      chk($time - t_csf == HALF_NS, "R7 lead", $time - t_csf, HALF_NS);
      first = 0;
    end
    rises++;
    if (exp_q.size() == 0) chk(0, "R4 extra sclk", rises, 0);
    else begin
      bit e;
      e = exp_q.pop_front();
      chk(mosi == e, "R3 mosi", mosi, e);
    end
  end
  always @(negedge sclk) begin
    t_fall = $time; fall_seen = 1; mi++;
  end
  always @(negedge cs_n) if (rst_n) begin
    t_csf = $time; first = 1; cs_falls++;
  end
  always @(posedge cs_n) if (rst_n && fall_seen) begin
    chk($time - t_fall == HALF_NS, "R7 trail", $time - t_fall, HALF_NS);
    fall_seen = 0;
  end
  always @(negedge clk) if (rst_n && done) begin
    done_cnt++;
    chk(cs_n && !busy, "R8 done at end", {cs_n, busy}, 2'b10);
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  // driver: loads regs, pushes expected MOSI bits, starts, then checks results
  task automatic xfer(input logic [47:0] txv, input int n, input logic [79:0] pat, input bit poke);
    int nn, d0, f0;
    logic [7:0] v;
    logic [79:0] chain;
    for (int i = 0; i < 6; i++) wr(5'd8 + 5'(i), txv[8*i +: 8]);
    wr(5'd1, 8'(n));
    nn = (n > 56) ? 56 : n;
    for (int k = 0; k < nn; k++) exp_q.push_back((k < 48) ? txv[47 - k] : 1'b0);
    miso_pat = pat; mi = 0; rises = 0; d0 = done_cnt; f0 = cs_falls;
    wr(5'd0, 8'h04);
    if (poke) begin
      rd(5'd0, v); chk(v[2] == 1'b1, "R8 start bit while busy", v, 8'h04);
      wr(5'd8, ~txv[7:0]);
      wr(5'd1, 8'd3);
    end
    if (nn == 0) begin
      repeat (3) @(negedge clk);
      chk(done_cnt == d0 + 1, "R10 done pulse", done_cnt - d0, 1);
      chk(cs_falls == f0, "R10 cs stays high", cs_falls - f0, 0);
      rd(5'd0, v); chk(v[2] == 1'b0, "R10 start bit", v, 0);
    end else begin
      while (done_cnt == d0) @(negedge clk);
      chk(rises == nn, "R4 sclk pulses", rises, nn);
      chk(exp_q.size() == 0, "R3 bits left", exp_q.size(), 0);
      chain = pat >> (80 - nn);
      for (int i = 0; i < 10; i++) begin
        rd(5'd16 + 5'(i), v);
        chk(v == chain[8*i +: 8], "R5 rx byte", v, chain[8*i +: 8]);
      end
      rd(5'd0, v); chk(v == 8'h00, "R8 start bit cleared", v, 0);
      if (poke) begin
        rd(5'd8, v); chk(v == txv[7:0], "R9 tx write ignored", v, txv[7:0]);
        rd(5'd1, v); chk(v == 8'(n), "R9 count write ignored", v, n);
      end
    end
    exp_q.delete();
  endtask

  initial begin
    #400us;
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && !sclk && !busy, "R1 pins", {cs_n, sclk, busy}, 3'b100);
    rd(5'd0, v); chk(v == 0, "R1 cmd", v, 0);
    rd(5'd1, v); chk(v == 0, "R1 count", v, 0);
    // R2 R3 R5: full 56-bit frame
    xfer(48'hAB_89_67_45_23_01, 56, 80'hC3A5_5A3C_F00F_1234_5678, 0);
    // R3: single byte
    xfer(48'h96_00_00_00_00_00, 8, 80'h6D00_0000_0000_0000_0000, 0);
    // R5 R6: length not a byte multiple
    xfer(48'hF1_E2_D3_C4_B5_A6, 13, 80'hB7E1_0000_0000_0000_0000, 0);
    // R4: clamp
    wr(5'd1, 8'd60); rd(5'd1, v); chk(v == 8'd56, "R4 clamp", v, 56);
    wr(5'd1, 8'd255); rd(5'd1, v); chk(v == 8'd56, "R4 clamp max", v, 56);
    // R9: writes during busy
    xfer(48'h5A_C3_00_00_11_22, 16, 80'h1F2E_0000_0000_0000_0000, 1);
    // R10: zero length
    xfer(48'h0, 0, 80'h0, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule